// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a bitstream into a target FPGA over a slave-serial configuration link. It drives three pins toward the target: an active-low program request, a configuration clock and a serial data line. It watches the target's two status lines. One is an init line, high when the target is ready and low while it clears its configuration memory. The other is a done line, which goes high when the target has accepted a complete image.

A single-cycle `start` pulse begins a run. The block first pulls the program request low and waits for the target to pull init low. It then releases the program request and waits for init to return high. Next it takes configuration bytes from an upstream valid/ready stream and shifts each one out, most significant bit first. The last byte carries a flag. After that byte the block waits for done.

Each of the three waits has its own timeout. A run ends with either a success flag or a two-bit error code. The timeout window and the width of each pin step are parameters counted in system clocks. Both status lines pass through a two-stage synchroniser before they are used.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, and whenever `busy` is low, `cfg_prog_n`, `cfg_clk` and `cfg_dout` are all high, and `s_ready` is low. After reset, `busy`, `done_ok` and `err` are 0.
- R2: A `start` pulse while idle raises `busy` and clears `done_ok` and `err`. On the next clock, `cfg_prog_n` goes low while `cfg_clk` and `cfg_dout` stay high.
- R3: `cfg_init` is seen through two synchroniser flops. `cfg_prog_n` returns high exactly three clocks after `cfg_init` falls at the pin. If init stays high for POLL_CYCLES*POLL_COUNT clocks after program goes low, the run ends with `err` = 1. The error is not reported earlier.
- R4: After program is released, the block waits for `cfg_init` to go high. If that wait lasts POLL_CYCLES*POLL_COUNT clocks, the run ends with `err` = 2.
- R5: Each bit is sent in four steps of STEP_CYCLES clocks each, in this order: clock low with data high; clock low with data equal to the bit; clock high with the data unchanged; clock high with data high. The clock therefore stays low for 2*STEP_CYCLES clocks before each rising edge.
- R6: Bytes are accepted on `s_data` when `s_valid` and `s_ready` are both high at a clock edge. `s_ready` is high only while the block waits for a byte. Each byte is sent most significant bit first. A byte sent with `s_last` high is the final one.
- R7: After the final bit, the block waits for `cfg_done` to go high. If it does, the run ends with `done_ok` = 1 and `err` = 0. If the wait lasts POLL_CYCLES*POLL_COUNT clocks, the run ends with `done_ok` = 0 and `err` = 3. `done_ok` and a nonzero `err` are never high together.
- R8: A `start` pulse while `busy` is high has no effect. Program is not reasserted and the byte stream carries on unchanged.
- R9: A target that responds within the timeout window completes a run normally, even when it responds close to the end of the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a configuration run |
| s_data | input | BYTE_W | Configuration byte from upstream |
| s_valid | input | 1 | `s_data` holds a byte |
| s_last | input | 1 | Marks the final byte of the image |
| s_ready | output | 1 | Block can take a byte this cycle |
| cfg_prog_n | output | 1 | Active-low program request to the target |
| cfg_clk | output | 1 | Configuration clock to the target |
| cfg_dout | output | 1 | Serial configuration data to the target |
| cfg_init | input | 1 | Target init status (asynchronous) |
| cfg_done | input | 1 | Target done status (asynchronous) |
| busy | output | 1 | A run is in progress |
| done_ok | output | 1 | The last run ended in success |
| err | output | 2 | Result code of the last run: 0 none, 1 init did not fall, 2 init did not rise, 3 done did not rise |

## Verification
The bench models a target with a configurable response delay and injected faults, against a random byte stream with random valid gaps. The first corner case is each handshake failing in turn. A design that mixed up the waits would report the wrong code or hang. The second is responses placed just inside and just beyond the timeout window, which exposes an off-by-a-poll window. The third is the exact three-clock latency from an init edge to program release. The captured bits are compared against an MSB-first expansion of the bytes, and the clock-low width is measured, which catches a reversed bit order or a skipped pin step. Finally, the bench sends a second start in the middle of a run, which would reprogram the target in a design that failed to ignore it.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_INIT_HI,
    ST_FETCH,
    ST_SHIFT,
    ST_WAIT_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    ERR_NONE          = 2'd0,
    ERR_INIT_STUCK_HI = 2'd1,
    ERR_INIT_STUCK_LO = 2'd2,
    ERR_NO_DONE       = 2'd3
  } cfg_err_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W       = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_poll_timer.sv
module cfg_poll_timer #(
  parameter int unsigned POLL_CYCLES = 250000,
  parameter int unsigned POLL_COUNT  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic expired
);
  localparam int unsigned SW = $clog2(POLL_CYCLES + 1);
  localparam int unsigned PW = $clog2(POLL_COUNT + 1);

  logic [SW-1:0] step_q;
  logic [PW-1:0] poll_q;
  logic          exp_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      step_q <= '0;
      poll_q <= '0;
      exp_q  <= 1'b0;
    end else if (!exp_q) begin
      if (step_q == SW'(POLL_CYCLES - 1)) begin
        step_q <= '0;
        poll_q <= poll_q + 1'b1;
        if (poll_q == PW'(POLL_COUNT - 1)) exp_q <= 1'b1;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  assign expired = exp_q;

  // R3, R4, R7: once the window has run out it stays out until restarted
  assert_expire_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (exp_q && !clr) |=> exp_q);
endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter #(
  parameter int unsigned STEP_CYCLES = 4,
  parameter int unsigned BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              cclk,
  output logic              dout,
  output logic              finish
);
  localparam int unsigned STW = $clog2(STEP_CYCLES + 1);
  localparam int unsigned BW  = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sreg_q;
  logic [STW-1:0]    step_q;
  logic [1:0]        phase_q;
  logic [BW-1:0]     bit_q;
  logic              active_q;
  logic              cclk_q, dout_q;
  logic              step_end;

  assign step_end = (step_q == STW'(STEP_CYCLES - 1));
  assign finish   = active_q && step_end && (phase_q == 2'd3) &&
                    (bit_q == BW'(BYTE_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q   <= '0;
      step_q   <= '0;
      phase_q  <= 2'd0;
      bit_q    <= '0;
      active_q <= 1'b0;
      cclk_q   <= 1'b1;
      dout_q   <= 1'b1;
    end else if (load) begin
      sreg_q   <= load_byte;
      step_q   <= '0;
      phase_q  <= 2'd0;
      bit_q    <= '0;
      active_q <= 1'b1;
      cclk_q   <= 1'b0;
      dout_q   <= 1'b1;
    end else if (active_q) begin
      if (!step_end) begin
        step_q <= step_q + 1'b1;
      end else begin
        step_q  <= '0;
        phase_q <= phase_q + 2'd1;
        case (phase_q)
          2'd0: dout_q <= sreg_q[BYTE_W-1];
          2'd1: cclk_q <= 1'b1;
          2'd2: dout_q <= 1'b1;
          default: begin
            sreg_q <= {sreg_q[BYTE_W-2:0], 1'b0};
            bit_q  <= bit_q + 1'b1;
            if (finish) active_q <= 1'b0;
            else        cclk_q   <= 1'b0;
          end
        endcase
      end
    end
  end

  assign cclk = cclk_q;
  assign dout = dout_q;

  // R5: data never moves on the rising clock edge
  assert_rise_stable_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cclk_q) |-> $stable(dout_q));
  // R5: the clock only falls while data rests high
  assert_fall_data_high_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(cclk_q) |-> dout_q);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 4,
  parameter int unsigned POLL_CYCLES = 250000,
  parameter int unsigned POLL_COUNT  = 4,
  parameter int unsigned BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic              cfg_prog_n,
  output logic              cfg_clk,
  output logic              cfg_dout,
  input  logic              cfg_init,
  input  logic              cfg_done,
  output logic              busy,
  output logic              done_ok,
  output logic [1:0]        err
);
  seq_state_t state_q, state_d;
  cfg_err_t   err_q, fin_code;
  logic       fin, load, last_q, prog_n_q, busy_q, ok_q;
  logic       init_s, done_s, tmr_exp, tmr_clr, sh_fin;

  cfg_sync #(.W(2), .STAGES(2), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst(rst),
    .d({cfg_done, cfg_init}),
    .q({done_s, init_s})
  );

  cfg_poll_timer #(.POLL_CYCLES(POLL_CYCLES), .POLL_COUNT(POLL_COUNT)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .expired(tmr_exp)
  );

  cfg_bit_shifter #(.STEP_CYCLES(STEP_CYCLES), .BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .load_byte(s_data),
    .cclk(cfg_clk), .dout(cfg_dout), .finish(sh_fin)
  );

  assign load    = (state_q == ST_FETCH) && s_valid;
  assign tmr_clr = (state_d != state_q);

  always_comb begin
    state_d  = state_q;
    fin      = 1'b0;
    fin_code = ERR_NONE;
    case (state_q)
      ST_IDLE:    if (start) state_d = ST_PROG;
      ST_PROG: begin
        if (!init_s) state_d = ST_INIT_HI;
        else if (tmr_exp) begin
          state_d = ST_IDLE; fin = 1'b1; fin_code = ERR_INIT_STUCK_HI;
        end
      end
      ST_INIT_HI: begin
        if (init_s) state_d = ST_FETCH;
        else if (tmr_exp) begin
          state_d = ST_IDLE; fin = 1'b1; fin_code = ERR_INIT_STUCK_LO;
        end
      end
      ST_FETCH:   if (s_valid) state_d = ST_SHIFT;
      ST_SHIFT:   if (sh_fin) state_d = last_q ? ST_WAIT_DONE : ST_FETCH;
      ST_WAIT_DONE: begin
        if (done_s) begin
          state_d = ST_IDLE; fin = 1'b1;
        end else if (tmr_exp) begin
          state_d = ST_IDLE; fin = 1'b1; fin_code = ERR_NO_DONE;
        end
      end
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      prog_n_q <= 1'b1;
      busy_q   <= 1'b0;
      ok_q     <= 1'b0;
      err_q    <= ERR_NONE;
      last_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      prog_n_q <= (state_d != ST_PROG);
      if (state_q == ST_IDLE && start) begin
        busy_q <= 1'b1;
        ok_q   <= 1'b0;
        err_q  <= ERR_NONE;
      end
      if (fin) begin
        busy_q <= 1'b0;
        ok_q   <= (fin_code == ERR_NONE);
        err_q  <= fin_code;
      end
      if (load) last_q <= s_last;
    end
  end

  assign s_ready    = (state_q == ST_FETCH);
  assign cfg_prog_n = prog_n_q;
  assign busy       = busy_q;
  assign done_ok    = ok_q;
  assign err        = err_q;

  // R1: pins rest high whenever no run is in progress
  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (prog_n_q && cfg_clk && cfg_dout));
  // R2: while program is asserted, clock and data stay high
  assert_prog_pins_high_R2: assert property (@(posedge clk) disable iff (rst)
    !prog_n_q |-> (cfg_clk && cfg_dout));
  // R6: bytes are only taken during a run
  assert_ready_in_run_R6: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> busy_q);
  // R7: success and an error code never show together
  assert_status_excl_R7: assert property (@(posedge clk) disable iff (rst)
    ok_q |-> (err_q == ERR_NONE));
  // R8: once released inside a run, program is not asserted again
  assert_no_reprogram_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && prog_n_q) |=> prog_n_q);
endmodule

// File: tb/sim_cfg_serial_loader.sv
`timescale 1ns/1ps
module sim_cfg_serial_loader;
  localparam int STEP = 2;
  localparam int PC   = 10;
  localparam int PN   = 4;

  logic       clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_valid = 1'b0, s_last = 1'b0;
  logic       s_ready, cfg_prog_n, cfg_clk, cfg_dout, busy, done_ok;
  logic [1:0] err;
  logic       cfg_init = 1'b1, cfg_done = 1'b0;

  always #2 clk = ~clk;

  cfg_serial_loader #(.STEP_CYCLES(STEP), .POLL_CYCLES(PC), .POLL_COUNT(PN), .BYTE_W(8)) u0 (
    .clk(clk), .rst(rst), .start(start), .s_data(s_data), .s_valid(s_valid),
    .s_last(s_last), .s_ready(s_ready), .cfg_prog_n(cfg_prog_n), .cfg_clk(cfg_clk),
    .cfg_dout(cfg_dout), .cfg_init(cfg_init), .cfg_done(cfg_done), .busy(busy),
    .done_ok(done_ok), .err(err)
  );

  int n_chk = 0, n_fail = 0;
  int fault = 0, lat = 3, exp_nbits = 0, nbits = 0, lo_cnt = 0, hi_cnt = 0;
  int ncyc = 0, t_fall = -100, t_rise = -100, lowlen = 0;
  bit prev_prog = 1'b1, prev_clk = 1'b1, mdl_clr = 1'b0, timing_bad = 1'b0;
  logic [0:127] cap;
  logic [7:0]   byts [16];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Target model and pin observer
  always @(negedge clk) begin
    ncyc++;
    if (mdl_clr) begin
      cfg_init = 1'b1; cfg_done = 1'b0; lo_cnt = 0; hi_cnt = 0; nbits = 0;
      timing_bad = 1'b0; lowlen = 0; t_fall = -100; t_rise = -100;
    end else begin
      if (!prev_prog && cfg_prog_n) t_rise = ncyc;
      if (!cfg_clk) lowlen++;
      if (cfg_clk && !prev_clk && cfg_prog_n) begin
        if (nbits < 128) cap[nbits] = cfg_dout;
        nbits++;
        if (lowlen != 2*STEP) timing_bad = 1'b1;
        lowlen = 0;
      end
      if (!cfg_prog_n) begin
        hi_cnt = 0; cfg_done = 1'b0;
        if (fault != 1 && cfg_init) begin
          if (lo_cnt >= lat) begin cfg_init = 1'b0; t_fall = ncyc; end
          else lo_cnt++;
        end
      end else begin
        lo_cnt = 0;
        if (!cfg_init && fault != 2) begin
          if (hi_cnt >= lat) cfg_init = 1'b1;
          else hi_cnt++;
        end
        if (fault != 3 && exp_nbits > 0 && nbits == exp_nbits) cfg_done = 1'b1;
      end
    end
    prev_prog = cfg_prog_n;
    prev_clk  = cfg_clk;
  end

  function automatic bit exp_bit(int k);
    return byts[k/8][7 - (k%8)];
  endfunction

  task automatic prep(int f, int l, int nb);
    fault = f; lat = l; exp_nbits = nb*8;
    @(negedge clk); #1 mdl_clr = 1'b1;
    @(negedge clk); #1 mdl_clr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send(int nb, int gap_pct);
    int i = 0;
    bit rdy;
    while (i < nb) begin
      @(negedge clk);
      if (!busy) break;
      if (int'($urandom % 100) < gap_pct) s_valid = 1'b0;
      else begin
        s_valid = 1'b1; s_data = byts[i]; s_last = (i == nb-1);
      end
      #1 rdy = s_ready;
      @(posedge clk);
      if (s_valid && rdy) i++;
    end
    @(negedge clk); s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic wait_idle(output bit ok);
    int c = 0;
    ok = 1'b1;
    while (busy) begin
      @(negedge clk);
      c++;
      if (c > 5000) begin ok = 1'b0; break; end
    end
  endtask

  task automatic check_bits(string req, int nb);
    int bad = 0;
    for (int k = 0; k < nb*8; k++) if (cap[k] !== exp_bit(k)) bad++;
    chk(nbits == nb*8, req, "bit count", nbits, nb*8);
    chk(bad == 0 && !timing_bad, req, "bit mismatches/timing", bad + int'(timing_bad), 0);
  endtask

  task automatic check_idle(string req);
    chk(cfg_prog_n && cfg_clk && cfg_dout && !s_ready, req, "idle pins high, ready low",
        {cfg_prog_n, cfg_clk, cfg_dout, s_ready}, 4'b1110);
  endtask

  task automatic run_ok(string req, int nb, int l, int gap);
    bit ok;
    prep(0, l, nb);
    pulse_start();
    chk(busy && err == 0 && !done_ok, "R2", "status cleared on start", {busy, done_ok, err}, 4'b1000);
    send(nb, gap);
    wait_idle(ok);
    chk(ok, req, "run finished", ok, 1);
    chk(done_ok && err == 0, req, "success status", {done_ok, err}, 3'b100);
    check_bits(req, nb);
    check_idle("R1");
  endtask

  initial begin
    bit ok, low_seen;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !done_ok && err == 0, "R1", "reset status", {busy, done_ok, err}, 0);
    check_idle("R1");

    // Directed run: one byte, pin ordering and sync latency
    byts[0] = 8'hA5;
    prep(0, 3, 1);
    pulse_start();
    chk(!cfg_prog_n && cfg_clk && cfg_dout && busy, "R2", "program low, clk/data high",
        {cfg_prog_n, cfg_clk, cfg_dout, busy}, 4'b0111);
    send(1, 0);
    wait_idle(ok);
    chk(t_rise - t_fall == 3, "R3", "init fall to program release clocks", t_rise - t_fall, 3);
    chk(done_ok && err == 0, "R7", "success after done", {done_ok, err}, 3'b100);
    check_bits("R5", 1);
    check_idle("R1");

    // R6: all-zero and all-one bytes back to back
    byts[0] = 8'h00; byts[1] = 8'hFF; byts[2] = 8'h81;
    run_ok("R6", 3, 2, 0);

    // R6: random streams with random gaps and target delays
    for (int r = 0; r < 6; r++) begin
      int nb = 1 + int'($urandom % 5);
      for (int i = 0; i < nb; i++) byts[i] = 8'($urandom);
      run_ok("R6", nb, 1 + int'($urandom % 20), int'($urandom % 50));
    end

    // R3: init never falls
    prep(1, 3, 1);
    pulse_start();
    repeat (28) @(negedge clk);
    chk(busy && err == 0, "R3", "no early timeout", {busy, err}, 3'b100);
    wait_idle(ok);
    chk(err == 1 && !done_ok, "R3", "init stuck high code", err, 1);
    check_idle("R1");

    // R4: init never rises again
    prep(2, 3, 1);
    pulse_start();
    wait_idle(ok);
    chk(err == 2 && !done_ok, "R4", "init stuck low code", err, 2);

    // R7: done never rises, all bits still delivered
    byts[0] = 8'h3C; byts[1] = 8'hC3;
    prep(3, 3, 2);
    pulse_start();
    chk(err == 0, "R2", "error cleared on start", err, 0);
    send(2, 20);
    wait_idle(ok);
    chk(err == 3 && !done_ok, "R7", "done timeout code", err, 3);
    check_bits("R7", 2);

    // R9: slow target just inside the window, then beyond it
    byts[0] = 8'h5A;
    run_ok("R9", 1, 30, 0);
    prep(0, 60, 1);
    pulse_start();
    wait_idle(ok);
    chk(err == 1, "R9", "response beyond window", err, 1);

    // R8: second start in the middle of a run
    byts[0] = 8'h12; byts[1] = 8'h34; byts[2] = 8'h56;
    prep(0, 3, 3);
    pulse_start();
    low_seen = 1'b0;
    fork
      send(3, 0);
      begin
        repeat (25) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (12) begin
          @(negedge clk);
          if (!cfg_prog_n) low_seen = 1'b1;
        end
      end
    join
    wait_idle(ok);
    chk(!low_seen, "R8", "program not reasserted", low_seen, 0);
    chk(done_ok && err == 0, "R8", "run completes", {done_ok, err}, 3'b100);
    check_bits("R8", 3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule